// File: doc/BRIEF.md
# Four-Mode Universal Shift Register

A parameterised register of `W` bits (default 4) that performs one of four operations at each rising clock edge: it keeps its contents, shifts toward the right end, shifts toward the left end, or takes a full word from the parallel data input. A 2-bit mode input selects the operation. Each shift direction has its own serial input, which supplies the bit that enters the end left empty by the shift.

The whole register is always visible on the parallel output. This lets the block serve as a serial-to-parallel converter, a parallel-to-serial converter, a delay line or a plain storage word. An active-low clear acts at once, with no clock edge needed, and holds every bit at zero for as long as it stays low, whatever the mode is. `q[W-1]` is the left end of the register and `q[0]` is the right end. `W` must be at least 2.

Top module: `univ_shift_reg`

## Requirements
- R1: With mode 2'b00 the register keeps its contents across the clock edge.
- R2: With mode 2'b01 each edge moves `q[i+1]` into `q[i]` and places `shr_in` in `q[W-1]`.
- R3: With mode 2'b10 each edge moves `q[i-1]` into `q[i]` and places `shl_in` in `q[0]`.
- R4: With mode 2'b11 the next edge copies `par_in` into the whole register.
- R5: Driving `clr_n` low sets `q` to zero at once, before any clock edge arrives.
- R6: While `clr_n` is low, clock edges leave `q` at zero in every mode, parallel load included.
- R7: A right shift with `shr_in` at 0 halves the unsigned value, and a left shift with `shl_in` at 0 doubles it modulo 2^W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Asynchronous clear, active low |
| mode | input | 2 | 00 hold, 01 shift right, 10 shift left, 11 parallel load |
| shr_in | input | 1 | Serial bit entering at the left end during a right shift |
| shl_in | input | 1 | Serial bit entering at the right end during a left shift |
| par_in | input | W | Parallel load word |
| q | output | W | Register contents, q[W-1] left end |

## Verification
The bench runs runs of right shifts fed with all ones and runs of left shifts fed with alternating bits. The filled end and the direction of travel together tell the two serial inputs apart, and they show whether the shift moves toward the correct end. Parallel loads of complementary words such as 0xA and 0x5 expose any swapped or stuck bit. Holds placed straight after a load show whether the contents are kept. A halve-then-double sequence on a known value confirms the arithmetic meaning of each direction. A clear is applied in each of the four modes: the bench reads the output in the middle of the cycle, before any edge, and again after an edge with the mode still selected. This separates an asynchronous clear from a synchronous one and confirms that clear overrides every mode. A long pseudo-random stream of modes and data then covers mixed sequences of operations.

// File: rtl/usr_pkg.sv
package usr_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD = 2'b00,
    MODE_SHR  = 2'b01,
    MODE_SHL  = 2'b10,
    MODE_LOAD = 2'b11
  } usr_mode_e;
endpackage

// File: rtl/usr_next_state.sv
module usr_next_state #(
  parameter int W = 4
) (
  input  usr_pkg::usr_mode_e sel,
  input  logic               shr_in,
  input  logic               shl_in,
  input  logic [W-1:0]       cur,
  input  logic [W-1:0]       par_in,
  output logic [W-1:0]       nxt
);
  localparam int MSB = W - 1;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic from_left;   // source when moving toward the right end
    logic from_right;  // source when moving toward the left end

    if (i == MSB) begin : g_top
      assign from_left = shr_in;
    end else begin : g_mid_l
      assign from_left = cur[i+1];
    end

    if (i == 0) begin : g_bot
      assign from_right = shl_in;
    end else begin : g_mid_r
      assign from_right = cur[i-1];
    end

    always_comb begin
      unique case (sel)
        usr_pkg::MODE_SHR:  nxt[i] = from_left;
        usr_pkg::MODE_SHL:  nxt[i] = from_right;
        usr_pkg::MODE_LOAD: nxt[i] = par_in[i];
        default:            nxt[i] = cur[i];
      endcase
    end
  end
endmodule

// File: rtl/usr_state_reg.sv
module usr_state_reg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) q <= '0;
    else        q <= d;
  end
endmodule

// File: rtl/univ_shift_reg.sv
module univ_shift_reg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic [1:0]   mode,
  input  logic         shr_in,
  input  logic         shl_in,
  input  logic [W-1:0] par_in,
  output logic [W-1:0] q
);
  import usr_pkg::*;

  usr_mode_e    sel;
  logic [W-1:0] nxt;

  assign sel = usr_mode_e'(mode);

  usr_next_state #(.W(W)) u_next (
    .sel    (sel),
    .shr_in (shr_in),
    .shl_in (shl_in),
    .cur    (q),
    .par_in (par_in),
    .nxt    (nxt)
  );

  usr_state_reg #(.W(W)) u_reg (
    .clk   (clk),
    .clr_n (clr_n),
    .d     (nxt),
    .q     (q)
  );

  AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!clr_n)
    mode == 2'b00 |=> $stable(q)); // R1
  AST_SHIFT_RIGHT: assert property (@(posedge clk) disable iff (!clr_n)
    mode == 2'b01 |=> q == {$past(shr_in), $past(q[W-1:1])}); // R2
  AST_SHIFT_LEFT: assert property (@(posedge clk) disable iff (!clr_n)
    mode == 2'b10 |=> q == {$past(q[W-2:0]), $past(shl_in)}); // R3
  AST_PAR_LOAD: assert property (@(posedge clk) disable iff (!clr_n)
    mode == 2'b11 |=> q == $past(par_in)); // R4
  AST_CLEAR_WINS: assert property (@(posedge clk)
    !clr_n |-> q == '0); // R6
endmodule

// File: tb/univ_shift_reg_bench.sv
module univ_shift_reg_bench;
  localparam int W = 4;
  localparam int WATCHDOG_NS = 400000;

  logic         clk = 1'b0;
  logic         clr_n = 1'b0;
  logic [1:0]   mode = 2'b00;
  logic         shr_in = 1'b0;
  logic         shl_in = 1'b0;
  logic [W-1:0] par_in = '0;
  logic [W-1:0] q;

  int checks = 0;
  int fails  = 0;
  int model  = 0;   // reference value as an integer

  always #2 clk = ~clk;

  univ_shift_reg #(.W(W)) u_univ_shift_reg (
    .clk(clk), .clr_n(clr_n), .mode(mode), .shr_in(shr_in),
    .shl_in(shl_in), .par_in(par_in), .q(q)
  );

  task automatic check(input string req, input int exp);
    checks++;
    if (int'(q) !== exp) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", req, q, exp);
    end
  endtask

  function automatic int predict(input int cur, input logic [1:0] m,
                                 input logic sr, input logic sl, input int d);
    int full;
    full = (1 << W);
    case (m)
      2'b01:   return (cur / 2) + (sr ? full / 2 : 0);
      2'b10:   return ((cur * 2) % full) + (sl ? 1 : 0);
      2'b11:   return d;
      default: return cur;
    endcase
  endfunction

  function automatic string tag(input logic [1:0] m);
    case (m)
      2'b01:   return "R2 shift right";
      2'b10:   return "R3 shift left";
      2'b11:   return "R4 load";
      default: return "R1 hold";
    endcase
  endfunction

  // drives at negedge, checks at the following negedge
  task automatic step(input logic [1:0] m, input logic sr, input logic sl,
                      input int d, input string req);
    int exp;
    mode = m; shr_in = sr; shl_in = sl; par_in = d[W-1:0];
    exp = predict(model, m, sr, sl, d);
    @(posedge clk);
    @(negedge clk);
    check(req, exp);
    model = exp;
  endtask

  initial begin : watchdog
    #(WATCHDOG_NS);
    fails++;
    $display("FAIL watchdog actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    check("R5 reset state", 0);
    clr_n = 1'b1;
    model = 0;

    // R4 load complementary words, R1 hold after each
    step(2'b11, 0, 0, 'hA, "R4 load A");
    step(2'b00, 1, 1, 'h3, "R1 hold A");
    step(2'b00, 0, 0, 'h5, "R1 hold A again");
    step(2'b11, 0, 0, 'h5, "R4 load 5");
    step(2'b00, 1, 0, 'hF, "R1 hold 5");

    // R2 right shifts fed with ones
    step(2'b11, 0, 0, 'h0, "R4 load 0");
    for (int i = 0; i < W + 1; i++) step(2'b01, 1, 0, 'h0, "R2 fill ones");
    // R3 left shifts fed with alternating bits
    for (int i = 0; i < W + 2; i++) step(2'b10, 1, i[0], 'hF, "R3 alternating");

    // R7 halve then double
    step(2'b11, 0, 0, 'hC, "R4 load C");
    step(2'b01, 0, 1, 'h0, "R7 halve C");
    check("R7 halve to 6", 'h6);
    step(2'b10, 1, 0, 'h0, "R7 double 6");
    check("R7 double to C", 'hC);
    step(2'b10, 0, 0, 'h0, "R7 double wraps");
    check("R7 double mod 2^W", 'h8);

    // R5/R6 clear in every mode
    for (int m = 0; m < 4; m++) begin
      step(2'b11, 0, 0, 'hB, "R4 preload");
      mode = m[1:0]; shr_in = 1'b1; shl_in = 1'b1; par_in = 'hF;
      #1 clr_n = 1'b0;
      #0.5;
      check("R5 async clear", 0);
      @(posedge clk);
      @(negedge clk);
      check("R6 clear overrides mode", 0);
      clr_n = 1'b1;
      model = 0;
    end

    // mixed stream
    for (int i = 0; i < 300; i++) begin
      logic [1:0] m;
      m = 2'($urandom_range(0, 3));
      step(m, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
           int'($urandom_range(0, (1 << W) - 1)), tag(m));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule